// File: doc/BRIEF.md
# Pipeline Hazard Interlock

This block is the stall and flush controller for an in-order scalar pipeline with five stages: fetch, decode, execute, memory and writeback. The pipeline has no forwarding paths. The register file is written in the first half of writeback and read in the second half of decode. A value can therefore be consumed once its producer has reached writeback, and a consumer must wait while the producer is still in execute or memory. Instructions and data share one memory port. Conditional branches are recognised in decode but resolve only in execute.

Each cycle the block looks at the sources of the decode-stage instruction, the destinations of the instructions in execute and memory, the memory stage's port request and the branch resolution from execute. From these it drives hold and bubble controls for the PC and the two front pipeline registers. It also grants the shared port to fetch or withholds it, and steers the PC redirect. A one-bit pending flag records a branch that has left decode and whose outcome is not yet known, so fetch stays held even if execute takes more than one cycle to resolve it.

Top module: `hazard_interlock`

## Requirements
- R1: When decode holds a valid instruction whose used, nonzero source register equals the destination of a valid, writing instruction in execute or in memory, and no taken branch resolves, the block drives pc_hold_o=1, if_id_hold_o=1, if_id_bubble_o=0 and id_ex_bubble_o=1.
- R2: A producer that has moved on from memory into writeback no longer stalls its consumer. In the first cycle where neither execute nor memory holds a matching writer, if_id_hold_o=0 and id_ex_bubble_o=0.
- R3: The following never cause a stall: source register 0, a source whose used bit is 0, and a producer whose write flag is 0. With no other hazard present, all four hold/bubble outputs are 0.
- R4: A valid load/store in the memory stage (mem_valid_i=1, mem_access_i=1) takes the shared port. fetch_req_o=0 that cycle, and unless R1 or R7 applies, pc_hold_o=1 and if_id_bubble_o=1 while id_ex_bubble_o=0.
- R5: A valid branch in decode with no R1 stall and no taken resolution moves on to execute (id_ex_bubble_o=0), and fetch is held (pc_hold_o=1, if_id_bubble_o=1).
- R6: After a branch has left decode, each cycle without br_valid_i keeps pc_hold_o=1 and, unless R1 applies, if_id_bubble_o=1.
- R7: br_valid_i=1 with br_taken_i=1 has priority over every other condition. It drives redirect_o=1, redirect_pc_o=br_target_i, pc_hold_o=0, if_id_hold_o=0, if_id_bubble_o=1 and id_ex_bubble_o=1, and it clears the pending branch.
- R8: br_valid_i=1 with br_taken_i=0 gives redirect_o=0 and redirect_pc_o=0. It clears the pending branch, so fetch resumes in that cycle unless another hazard holds it.
- R9: During and after reset no branch is pending. With idle inputs the block drives fetch_req_o=1 and all other outputs 0.
- R10: if_id_hold_o and if_id_bubble_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds an instruction |
| id_src_used_i | input | NUM_SRC | Per source: the instruction reads it |
| id_src_i | input | NUM_SRC*REG_W | Source register numbers |
| id_is_branch_i | input | 1 | Decode instruction is a conditional branch |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_rd_i | input | REG_W | Execute destination register |
| mem_valid_i | input | 1 | Memory stage holds an instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | REG_W | Memory-stage destination register |
| mem_access_i | input | 1 | Memory-stage instruction is a load/store |
| br_valid_i | input | 1 | Branch outcome known in execute |
| br_taken_i | input | 1 | Resolved branch is taken |
| br_target_i | input | XLEN | Resolved branch target |
| fetch_req_o | output | 1 | Shared port granted to fetch |
| pc_hold_o | output | 1 | PC keeps its value |
| if_id_hold_o | output | 1 | Fetch/decode register keeps its value |
| if_id_bubble_o | output | 1 | Fetch/decode register loads a no-op |
| id_ex_bubble_o | output | 1 | Decode/execute register loads a no-op |
| redirect_o | output | 1 | PC loads redirect_pc_o |
| redirect_pc_o | output | XLEN | Redirect target, 0 when not redirecting |

## Verification
Directed cases come first. One places a producer in execute and then in memory and then removes it, which shows that the stall window ends at writeback rather than one cycle early or late. Others vary register 0, clear the used and write flags, and drive a taken resolution together with a data hazard and a port conflict, which separates a correct match from an over-eager one and shows which condition wins. A branch run with one idle cycle before resolution, followed by taken and not-taken outcomes, shows that the pending flag both holds fetch and clears. After that, seeded random cycles draw registers from a small range so that matches are frequent. Each cycle is compared with a model built from the requirements.

// File: rtl/hazard_interlock_pkg.sv
package hazard_interlock_pkg;

  typedef enum logic [1:0] {
    ACT_RUN,
    ACT_FETCH_BLOCK,
    ACT_STALL,
    ACT_FLUSH
  } hz_act_e;

  typedef struct packed {
    logic pc_hold;
    logic if_id_hold;
    logic if_id_bubble;
    logic id_ex_bubble;
  } hz_ctrl_t;

  function automatic hz_ctrl_t act_to_ctrl(hz_act_e act);
    hz_ctrl_t c;
    c = '0;
    unique case (act)
      ACT_RUN:         c = '0;
      ACT_FETCH_BLOCK: begin c.pc_hold = 1'b1; c.if_id_bubble = 1'b1; end
      ACT_STALL:       begin c.pc_hold = 1'b1; c.if_id_hold = 1'b1; c.id_ex_bubble = 1'b1; end
      ACT_FLUSH:       begin c.if_id_bubble = 1'b1; c.id_ex_bubble = 1'b1; end
      default:         c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/hzd_raw_detect.sv
module hzd_raw_detect #(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned NUM_SRC  = 2,
  parameter int unsigned NUM_PROD = 2
) (
  input  logic                               cons_valid_i,
  input  logic [NUM_SRC-1:0]                 cons_used_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]      cons_src_i,
  input  logic [NUM_PROD-1:0]                prod_wr_i,
  input  logic [NUM_PROD-1:0][REG_W-1:0]     prod_rd_i,
  output logic                               raw_o
);
  localparam int unsigned NUM_PAIR = NUM_SRC * NUM_PROD;

  logic [NUM_PAIR-1:0] pair_hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic src_live;
    // register 0 is hardwired, never a dependence
    assign src_live = cons_used_i[s] && (cons_src_i[s] != '0);
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
      assign pair_hit[s*NUM_PROD+p] = src_live && prod_wr_i[p] &&
                                      (prod_rd_i[p] == cons_src_i[s]);
    end
  end

  assign raw_o = cons_valid_i && (|pair_hit);

endmodule

// File: rtl/hzd_port_arb.sv
module hzd_port_arb (
  input  logic mem_valid_i,
  input  logic mem_access_i,
  output logic conflict_o,
  output logic fetch_grant_o
);
  // data access wins; fetch retries once the port is free
  assign conflict_o    = mem_valid_i && mem_access_i;
  assign fetch_grant_o = !conflict_o;
endmodule

// File: rtl/hzd_branch_ctrl.sv
module hzd_branch_ctrl #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            br_in_decode_i,
  input  logic            decode_stall_i,
  input  logic            br_valid_i,
  input  logic            br_taken_i,
  input  logic [XLEN-1:0] br_target_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            br_leave_o,
  output logic            br_wait_o
);
  logic pend_q, pend_d;

  assign redirect_o    = br_valid_i && br_taken_i;
  assign redirect_pc_o = redirect_o ? br_target_i : '0;
  assign br_leave_o    = br_in_decode_i && !decode_stall_i && !redirect_o;
  assign br_wait_o     = pend_q && !br_valid_i;
  assign pend_d        = br_leave_o || br_wait_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock
  import hazard_interlock_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          id_valid_i,
  input  logic [NUM_SRC-1:0]            id_src_used_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  input  logic                          id_is_branch_i,
  input  logic                          ex_valid_i,
  input  logic                          ex_wr_i,
  input  logic [REG_W-1:0]              ex_rd_i,
  input  logic                          mem_valid_i,
  input  logic                          mem_wr_i,
  input  logic [REG_W-1:0]              mem_rd_i,
  input  logic                          mem_access_i,
  input  logic                          br_valid_i,
  input  logic                          br_taken_i,
  input  logic [XLEN-1:0]               br_target_i,
  output logic                          fetch_req_o,
  output logic                          pc_hold_o,
  output logic                          if_id_hold_o,
  output logic                          if_id_bubble_o,
  output logic                          id_ex_bubble_o,
  output logic                          redirect_o,
  output logic [XLEN-1:0]               redirect_pc_o
);
  localparam int unsigned NUM_PROD = 2; // execute, memory

  logic [NUM_PROD-1:0]            prod_wr;
  logic [NUM_PROD-1:0][REG_W-1:0] prod_rd;
  logic raw, conflict, br_leave, br_wait, redirect;
  hz_act_e  act;
  hz_ctrl_t ctrl;

  assign prod_wr = {mem_valid_i && mem_wr_i, ex_valid_i && ex_wr_i};
  assign prod_rd = {mem_rd_i, ex_rd_i};

  hzd_raw_detect #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC),
    .NUM_PROD(NUM_PROD)
  ) u_raw (
    .cons_valid_i(id_valid_i),
    .cons_used_i (id_src_used_i),
    .cons_src_i  (id_src_i),
    .prod_wr_i   (prod_wr),
    .prod_rd_i   (prod_rd),
    .raw_o       (raw)
  );

  hzd_port_arb u_arb (
    .mem_valid_i  (mem_valid_i),
    .mem_access_i (mem_access_i),
    .conflict_o   (conflict),
    .fetch_grant_o(fetch_req_o)
  );

  hzd_branch_ctrl #(.XLEN(XLEN)) u_br (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .br_in_decode_i(id_valid_i && id_is_branch_i),
    .decode_stall_i(raw),
    .br_valid_i    (br_valid_i),
    .br_taken_i    (br_taken_i),
    .br_target_i   (br_target_i),
    .redirect_o    (redirect),
    .redirect_pc_o (redirect_pc_o),
    .br_leave_o    (br_leave),
    .br_wait_o     (br_wait)
  );

  // priority: flush > data stall > fetch block
  always_comb begin
    if (redirect)                           act = ACT_FLUSH;
    else if (raw)                           act = ACT_STALL;
    else if (conflict || br_leave || br_wait) act = ACT_FETCH_BLOCK;
    else                                    act = ACT_RUN;
  end

  assign ctrl           = act_to_ctrl(act);
  assign pc_hold_o      = ctrl.pc_hold;
  assign if_id_hold_o   = ctrl.if_id_hold;
  assign if_id_bubble_o = ctrl.if_id_bubble;
  assign id_ex_bubble_o = ctrl.id_ex_bubble;
  assign redirect_o     = redirect;

endmodule

// File: rtl/hazard_interlock_chk.sv
module hazard_interlock_chk #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_SRC = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          id_valid_i,
  input logic [NUM_SRC-1:0]            id_src_used_i,
  input logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  input logic                          id_is_branch_i,
  input logic                          ex_valid_i,
  input logic                          ex_wr_i,
  input logic [REG_W-1:0]              ex_rd_i,
  input logic                          mem_valid_i,
  input logic                          mem_wr_i,
  input logic [REG_W-1:0]              mem_rd_i,
  input logic                          mem_access_i,
  input logic                          br_valid_i,
  input logic                          br_taken_i,
  input logic [XLEN-1:0]               br_target_i,
  input logic                          fetch_req_o,
  input logic                          pc_hold_o,
  input logic                          if_id_hold_o,
  input logic                          if_id_bubble_o,
  input logic                          id_ex_bubble_o,
  input logic                          redirect_o,
  input logic [XLEN-1:0]               redirect_pc_o
);
  logic dep;

  always_comb begin
    dep = 1'b0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (id_src_used_i[s] && id_src_i[s] != '0) begin
        if (ex_valid_i && ex_wr_i && ex_rd_i == id_src_i[s])    dep = 1'b1;
        if (mem_valid_i && mem_wr_i && mem_rd_i == id_src_i[s]) dep = 1'b1;
      end
    end
    dep = dep && id_valid_i;
  end

  AST_RAW_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dep |-> redirect_o || (pc_hold_o && if_id_hold_o && id_ex_bubble_o)); // R1

  AST_NO_FALSE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dep |-> !if_id_hold_o); // R3

  AST_PORT_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && mem_access_i) |-> !fetch_req_o && (pc_hold_o || redirect_o)); // R4

  AST_BR_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(id_valid_i && id_is_branch_i && !if_id_hold_o && !redirect_o)
     && !br_valid_i) |-> pc_hold_o); // R6

  AST_FLUSH_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && br_taken_i) |-> redirect_o && if_id_bubble_o && id_ex_bubble_o
                                   && !pc_hold_o && !if_id_hold_o
                                   && redirect_pc_o == br_target_i); // R7

  AST_NT_NO_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(br_valid_i && br_taken_i) |-> !redirect_o && redirect_pc_o == '0); // R8

  AST_HOLD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(if_id_hold_o && if_id_bubble_o)); // R10

endmodule

bind hazard_interlock hazard_interlock_chk #(
  .REG_W  (REG_W),
  .XLEN   (XLEN),
  .NUM_SRC(NUM_SRC)
) u_chk (.*);

// File: tb/hazard_interlock_bench.sv
module hazard_interlock_bench;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned NUM_SRC = 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic id_valid_i, id_is_branch_i;
  logic [NUM_SRC-1:0] id_src_used_i;
  logic [NUM_SRC-1:0][REG_W-1:0] id_src_i;
  logic ex_valid_i, ex_wr_i, mem_valid_i, mem_wr_i, mem_access_i;
  logic [REG_W-1:0] ex_rd_i, mem_rd_i;
  logic br_valid_i, br_taken_i;
  logic [XLEN-1:0] br_target_i;
  logic fetch_req_o, pc_hold_o, if_id_hold_o, if_id_bubble_o, id_ex_bubble_o, redirect_o;
  logic [XLEN-1:0] redirect_pc_o;

  int checks = 0;
  int errors = 0;
  logic model_pend = 1'b0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hazard_interlock #(.REG_W(REG_W), .XLEN(XLEN), .NUM_SRC(NUM_SRC)) u_hazard_interlock (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    id_valid_i = 0; id_is_branch_i = 0; id_src_used_i = '0; id_src_i = '0;
    ex_valid_i = 0; ex_wr_i = 0; ex_rd_i = '0;
    mem_valid_i = 0; mem_wr_i = 0; mem_rd_i = '0; mem_access_i = 0;
    br_valid_i = 0; br_taken_i = 0; br_target_i = '0;
  endtask

  function automatic logic dep_hit();
    logic h = 1'b0;
    for (int s = 0; s < NUM_SRC; s++)
      if (id_src_used_i[s] && id_src_i[s] != 0 &&
          ((ex_valid_i && ex_wr_i && ex_rd_i == id_src_i[s]) ||
           (mem_valid_i && mem_wr_i && mem_rd_i == id_src_i[s]))) h = 1'b1;
    return h && id_valid_i;
  endfunction

  // checks current cycle against requirement model, then advances one clock
  task automatic cycle(input string tag_ov);
    logic redir, raw, leave, wt, conf, nxt;
    logic [3:0] e;
    string tag;
    #1;
    redir = br_valid_i && br_taken_i;
    raw   = dep_hit();
    leave = id_valid_i && id_is_branch_i && !raw && !redir;
    wt    = model_pend && !br_valid_i;
    conf  = mem_valid_i && mem_access_i;
    if (redir)                    begin e = 4'b0011; tag = "R7"; end
    else if (raw)                 begin e = 4'b1101; tag = "R1"; end
    else if (conf)                begin e = 4'b1010; tag = "R4"; end
    else if (leave)               begin e = 4'b1010; tag = "R5"; end
    else if (wt)                  begin e = 4'b1010; tag = "R6"; end
    else if (br_valid_i)          begin e = 4'b0000; tag = "R8"; end
    else                          begin e = 4'b0000; tag = "R3"; end
    if (tag_ov != "") tag = tag_ov;
    chk(tag, "pc_hold",      32'(pc_hold_o),      32'(e[3]));
    chk(tag, "if_id_hold",   32'(if_id_hold_o),   32'(e[2]));
    chk(tag, "if_id_bubble", 32'(if_id_bubble_o), 32'(e[1]));
    chk(tag, "id_ex_bubble", 32'(id_ex_bubble_o), 32'(e[0]));
    chk(conf ? "R4" : tag, "fetch_req", 32'(fetch_req_o), 32'(!conf));
    chk(redir ? "R7" : "R8", "redirect", 32'(redirect_o), 32'(redir));
    chk(redir ? "R7" : "R8", "redirect_pc", redirect_pc_o, redir ? br_target_i : 32'h0);
    chk("R10", "hold_and_bubble", 32'(if_id_hold_o && if_id_bubble_o), 32'h0);
    nxt = leave || wt;
    @(negedge clk_i);
    model_pend = rst_ni ? nxt : 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5eed_1234);
    idle();
    @(negedge clk_i);
    cycle("R9");               // in reset, idle inputs
    cycle("R9");
    rst_ni = 1'b1;
    cycle("R9");               // first cycle out of reset

    // R1: execute writer matches source 0
    idle(); id_valid_i = 1; id_src_used_i = 2'b01; id_src_i[0] = 5'd5;
    ex_valid_i = 1; ex_wr_i = 1; ex_rd_i = 5'd5;
    cycle("R1");
    // R1 then R2: producer in ex, mem, then gone to writeback
    idle(); id_valid_i = 1; id_src_used_i = 2'b10; id_src_i[1] = 5'd7;
    ex_valid_i = 1; ex_wr_i = 1; ex_rd_i = 5'd7;
    cycle("R1");
    ex_valid_i = 0; mem_valid_i = 1; mem_wr_i = 1; mem_rd_i = 5'd7;
    cycle("R1");
    mem_valid_i = 0;
    cycle("R2");
    // R3: register 0, unused source, non-writing producer
    idle(); id_valid_i = 1; id_src_used_i = 2'b11; id_src_i = '0;
    ex_valid_i = 1; ex_wr_i = 1; ex_rd_i = 5'd0;
    cycle("R3");
    id_src_i[0] = 5'd9; id_src_used_i = 2'b10; ex_rd_i = 5'd9;
    cycle("R3");
    id_src_used_i = 2'b11; ex_wr_i = 0; mem_valid_i = 1; mem_wr_i = 0; mem_rd_i = 5'd9;
    cycle("R3");
    // R4: load/store holds the port
    idle(); mem_valid_i = 1; mem_access_i = 1;
    cycle("R4");
    // R5, R6, R7 branch sequence
    idle(); id_valid_i = 1; id_is_branch_i = 1;
    cycle("R5");
    idle();
    cycle("R6");
    br_valid_i = 1; br_taken_i = 1; br_target_i = 32'h0000_4000;
    cycle("R7");
    idle();
    cycle("R7");               // pending cleared by taken resolution
    // R8: not-taken releases fetch
    id_valid_i = 1; id_is_branch_i = 1;
    cycle("R5");
    idle(); br_valid_i = 1; br_taken_i = 0; br_target_i = 32'hdead_beef;
    cycle("R8");
    idle();
    cycle("R8");
    // R7 priority over data stall and port conflict
    id_valid_i = 1; id_src_used_i = 2'b01; id_src_i[0] = 5'd3;
    ex_valid_i = 1; ex_wr_i = 1; ex_rd_i = 5'd3;
    mem_valid_i = 1; mem_access_i = 1;
    br_valid_i = 1; br_taken_i = 1; br_target_i = 32'h0000_0100;
    cycle("R7");
    // R9: reset while a branch is pending
    idle(); id_valid_i = 1; id_is_branch_i = 1;
    cycle("R5");
    idle(); rst_ni = 1'b0; model_pend = 1'b0;
    cycle("R9");
    rst_ni = 1'b1;
    cycle("R9");

    // seeded random traffic
    for (int i = 0; i < 4000; i++) begin
      id_valid_i     = ($urandom % 4) != 0;
      id_is_branch_i = ($urandom % 5) == 0;
      id_src_used_i  = 2'($urandom);
      for (int s = 0; s < NUM_SRC; s++) id_src_i[s] = 5'($urandom % 4);
      ex_valid_i   = $urandom % 2; ex_wr_i  = $urandom % 2; ex_rd_i  = 5'($urandom % 4);
      mem_valid_i  = $urandom % 2; mem_wr_i = $urandom % 2; mem_rd_i = 5'($urandom % 4);
      mem_access_i = ($urandom % 3) == 0;
      br_valid_i   = ($urandom % 4) == 0;
      br_taken_i   = $urandom % 2;
      br_target_i  = $urandom;
      cycle("");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule